// File: doc/BRIEF.md
# Four-Stage Arithmetic Pipeline with Class-Timed Third Stage

This block is a four-stage arithmetic pipeline whose third stage takes a different number of cycles depending on a class tag that travels with each operation. Each accepted operation carries two operands and a 2-bit class tag. The first stage adds the operands. The second stage multiplies that sum by three using a shift and an add. The third stage adds a class-dependent constant. The fourth stage XORs the value with a fixed mask and presents it as the result.

A fast operation occupies the third stage for one cycle, a medium one for two and a slow one for three. While the third stage is still working on an operation, the first two stages freeze and the input stops accepting. The fourth stage receives an empty slot (a bubble) for each such cycle. Results leave in the order the operations entered.

The input is valid/ready. An operation is taken on a rising edge where `in_valid` and `in_ready` are both high. A source holding `in_valid` high must keep its operands and tag unchanged until that edge. `in_ready` depends only on internal state and never on `in_valid`. The output has no back-pressure: `out_valid` marks `out_data` valid for exactly one cycle.

Top module: `varlat_pipe`

## Requirements
- R1: Each result equals ((in_a + in_b) * 3 + k) XOR OUT_MASK, modulo 2^W. The constant k is 1 for class 00, 2 for class 01, 3 for class 10 and 1 for class 11. The default OUT_MASK is 16'h5A5A.
- R2: A fast operation (class 00) accepted on edge n, with no stall pending, gives `out_valid` high in the cycle after edge n+3.
- R3: A medium operation (class 01) accepted on edge n, with no stall pending, gives its result in the cycle after edge n+4.
- R4: A slow operation (class 10) accepted on edge n, with no stall pending, gives its result in the cycle after edge n+5. `in_ready` is never low for more than two consecutive cycles.
- R5: Class 11 behaves exactly like class 00, in both latency and constant.
- R6: Each medium operation drops `in_ready` for exactly one cycle and each slow operation for exactly two. While `in_ready` is low, stages one to three keep their contents.
- R7: A cycle in which `in_ready` is low is always followed by a cycle with `out_valid` low.
- R8: Results appear in acceptance order, one per accepted operation, with none lost or duplicated.
- R9: A back-to-back stream of fast operations yields one result per cycle once the pipeline has filled.
- R10: Synchronous active-high `rst` clears all stage valid bits and the third-stage counter. After reset, `out_valid` is low and `in_ready` is high, even when reset hits during a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Pipeline can take an operation this cycle |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| in_cls | input | 2 | Class: 00 fast, 01 medium, 10 slow, 11 fast |
| out_valid | output | 1 | Result valid this cycle |
| out_data | output | W | Result |

## Verification
Single operations sent one at a time for each of the four class codes measure the exact latency of each class. They also show that code 11 cannot be told apart from code 00. A dense run of fast operations separates full throughput from any hidden stall. A mixed slow, fast and medium burst shows that frozen upstream stages keep their data and order. Long random runs with gaps in `in_valid` check that the total number of cycles with `in_ready` low matches the sum of the per-class penalties. A reset applied in the middle of a slow operation shows that the busy counter is cleared and the dropped operation never reaches the output.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
  typedef enum logic [1:0] {
    CLS_FAST = 2'b00,
    CLS_MED  = 2'b01,
    CLS_SLOW = 2'b10,
    CLS_ALT  = 2'b11
  } op_cls_e;

  localparam int HOLD_W = 2;

  // Number of cycles beyond the first that stage three keeps an operation.
  function automatic logic [HOLD_W-1:0] extra_cycles(input logic [1:0] cls);
    case (op_cls_e'(cls))
      CLS_MED:  return 2'd1;
      CLS_SLOW: return 2'd2;
      default:  return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/vlp_stage.sv
module vlp_stage #(
  parameter int W  = 16,
  parameter int OP = 0          // 0: d + e, 1: (d << 1) + e
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  input  logic [W-1:0] in_e,
  input  logic [1:0]   in_cls,
  output logic         out_v,
  output logic [W-1:0] out_d,
  output logic [1:0]   out_cls
);
  logic [W-1:0] f;

  generate
    if (OP == 0) begin : g_add
      assign f = in_d + in_e;
    end else begin : g_shadd
      assign f = (in_d << 1) + in_e;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v <= 1'b0;
    end else if (en) begin
      out_v   <= in_v;
      out_d   <= f;
      out_cls <= in_cls;
    end
  end
endmodule

// File: rtl/vlp_hold_stage.sv
module vlp_hold_stage
  import vlp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  input  logic [1:0]   in_cls,
  output logic         out_v,
  output logic [W-1:0] out_d,
  output logic         busy
);
  logic              v_q;
  logic [W-1:0]      d_q;
  logic [HOLD_W-1:0] cnt_q;
  logic [HOLD_W-1:0] ext;

  assign ext   = extra_cycles(in_cls);
  assign busy  = v_q && (cnt_q != '0);
  assign out_v = v_q && !busy;
  assign out_d = d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q   <= 1'b0;
      cnt_q <= '0;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      v_q   <= in_v;
      cnt_q <= in_v ? ext : '0;
      d_q   <= in_d + W'(ext) + W'(1);
    end
  end
endmodule

// File: rtl/vlp_out_stage.sv
module vlp_out_stage #(
  parameter int           W    = 16,
  parameter logic [W-1:0] MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_v <= 1'b0;
    end else begin
      out_v <= in_v;
      out_d <= in_d ^ MASK;
    end
  end
endmodule

// File: rtl/varlat_pipe.sv
module varlat_pipe #(
  parameter int           W        = 16,
  parameter logic [W-1:0] OUT_MASK = W'(16'h5A5A)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [1:0]   in_cls,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic         s1_v, s2_v, s3_v;
  logic [W-1:0] s1_d, s2_d, s3_d;
  logic [1:0]   s1_cls, s2_cls;
  logic         s3_busy;
  logic         adv;

  assign adv      = !s3_busy;
  assign in_ready = adv;

  vlp_stage #(.W(W), .OP(0)) u_s1 (
    .clk(clk), .rst(rst), .en(adv),
    .in_v(in_valid), .in_d(in_a), .in_e(in_b), .in_cls(in_cls),
    .out_v(s1_v), .out_d(s1_d), .out_cls(s1_cls)
  );

  vlp_stage #(.W(W), .OP(1)) u_s2 (
    .clk(clk), .rst(rst), .en(adv),
    .in_v(s1_v), .in_d(s1_d), .in_e(s1_d), .in_cls(s1_cls),
    .out_v(s2_v), .out_d(s2_d), .out_cls(s2_cls)
  );

  vlp_hold_stage #(.W(W)) u_s3 (
    .clk(clk), .rst(rst),
    .in_v(s2_v), .in_d(s2_d), .in_cls(s2_cls),
    .out_v(s3_v), .out_d(s3_d), .busy(s3_busy)
  );

  vlp_out_stage #(.W(W), .MASK(OUT_MASK)) u_s4 (
    .clk(clk), .rst(rst),
    .in_v(s3_v), .in_d(s3_d),
    .out_v(out_valid), .out_d(out_data)
  );
endmodule

// File: rtl/vlp_chk.sv
module vlp_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_ready,
  input logic         out_valid,
  input logic         s1_v,
  input logic [W-1:0] s1_d,
  input logic [W-1:0] s3_d
);
  logic prev_stall;

  always_ff @(posedge clk) begin
    if (rst) prev_stall <= 1'b0;
    else     prev_stall <= !in_ready;
  end

  // R7: a stalled cycle sends a bubble to the output stage
  p_bubble_r7: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> !out_valid);

  // R6: the first stage keeps its contents while stalled
  p_s1_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> ($stable(s1_v) && $stable(s1_d)));

  // R6: the third stage keeps its value while working
  p_s3_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> $stable(s3_d));

  // R4: no stall lasts longer than two cycles
  p_stall_max_r4: assert property (@(posedge clk) disable iff (rst)
    (prev_stall && !in_ready) |=> in_ready);
endmodule

bind varlat_pipe vlp_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .s1_v(s1_v), .s1_d(s1_d), .s3_d(s3_d)
);

// File: tb/sim_varlat_pipe.sv
module sim_varlat_pipe;
  localparam int W = 16;
  localparam logic [W-1:0] MASK = 16'h5A5A;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic [1:0]   in_cls = 2'b00;
  logic         out_valid;
  logic [W-1:0] out_data;

  varlat_pipe u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_cls(in_cls),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #4 clk = ~clk;  // 125 MHz

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [W-1:0] exp_q[$];
  int acc_q[$];
  int ext_q[$];
  string tag_q[$];
  bit lat_mode = 1'b0;
  string cur_tag = "R1";
  int stall_seen = 0, stall_exp = 0;
  bit prev_stall = 1'b0;
  bit finished = 1'b0;

  function automatic int ext_of(input logic [1:0] c);
    return (c == 2'b01) ? 1 : (c == 2'b10) ? 2 : 0;
  endfunction

  function automatic logic [W-1:0] model(input logic [W-1:0] a, b, input logic [1:0] c);
    logic [W-1:0] s;
    s = a + b;
    s = s * 3;
    s = s + W'(ext_of(c) + 1);
    return s ^ MASK;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) if (cyc > 150000 && !finished) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    summary();
  end

  // Monitor: samples away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 extra result", 1, 0);
        end else begin
          logic [W-1:0] e;
          int a, x;
          string t;
          e = exp_q.pop_front(); a = acc_q.pop_front();
          x = ext_q.pop_front(); t = tag_q.pop_front();
          chk(out_data == e, "R1 R8 data", out_data, e);
          if (t != "") chk(cyc == a + 4 + x, t, cyc, a + 4 + x);
        end
      end
      if (prev_stall) chk(!out_valid, "R7 bubble", out_valid, 0);
      prev_stall = !in_ready;
      if (!in_ready) stall_seen++;
      if (in_valid && in_ready) begin
        exp_q.push_back(model(in_a, in_b, in_cls));
        acc_q.push_back(cyc);
        ext_q.push_back(ext_of(in_cls));
        tag_q.push_back(lat_mode ? cur_tag : "");
        stall_exp += ext_of(in_cls);
      end
    end else begin
      prev_stall = 1'b0;
    end
  end

  task automatic send(input logic [W-1:0] a, b, input logic [1:0] c);
    bit ok;
    in_valid = 1'b1; in_a = a; in_b = b; in_cls = c;
    do begin
      @(negedge clk); ok = in_ready;
      @(posedge clk); #2;
    end while (!ok);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 200) begin
      @(posedge clk); #2; guard++;
    end
    chk(exp_q.size() == 0, "R8 drain", exp_q.size(), 0);
    repeat (3) @(posedge clk); #2;
  endtask

  initial begin
    int seed = 32'h1234_5678;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R10 reset out_valid", out_valid, 0);
    chk(in_ready, "R10 reset in_ready", in_ready, 1);
    @(posedge clk); #2;

    // Isolated operations, one per class code.
    lat_mode = 1'b1;
    cur_tag = "R2 fast latency";   send(16'd10, 16'd20, 2'b00);    drain();
    cur_tag = "R3 medium latency"; send(16'd7, 16'd9, 2'b01);      drain();
    cur_tag = "R4 slow latency";   send(16'hFFFF, 16'd3, 2'b10);   drain();
    cur_tag = "R5 class 11 latency"; send(16'd100, 16'd55, 2'b11); drain();

    // Back-to-back fast stream.
    cur_tag = "R9 fast stream";
    for (int i = 0; i < 8; i++) send(16'(i * 37), 16'(i + 1), 2'b00);
    drain();
    lat_mode = 1'b0;

    // Mixed burst: slow, fast, medium back to back.
    send(16'd1, 16'd2, 2'b10); send(16'd3, 16'd4, 2'b00);
    send(16'd5, 16'd6, 2'b01); send(16'd7, 16'd8, 2'b10);
    send(16'd9, 16'd10, 2'b11);
    drain();
    chk(stall_seen == stall_exp, "R6 stall cycles directed", stall_seen, stall_exp);

    // Random traffic with gaps.
    for (int i = 0; i < 400; i++) begin
      int gap;
      gap = int'($urandom % 4);
      if (gap == 0) begin @(posedge clk); #2; end
      send(16'($urandom), 16'($urandom), 2'($urandom));
    end
    drain();
    chk(stall_seen == stall_exp, "R6 stall cycles random", stall_seen, stall_exp);

    // Reset during a slow operation.
    send(16'd42, 16'd1, 2'b10);
    repeat (3) @(posedge clk); #2;
    rst = 1'b1;
    @(posedge clk); #2;
    rst = 1'b0;
    exp_q.delete(); acc_q.delete(); ext_q.delete(); tag_q.delete();
    @(negedge clk);
    chk(in_ready, "R10 mid reset in_ready", in_ready, 1);
    chk(!out_valid, "R10 mid reset out_valid", out_valid, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!out_valid, "R10 dropped op stays gone", out_valid, 0);
    end

    finished = 1'b1;
    summary();
  end
endmodule